// File: doc/BRIEF.md
# NOR Toggle-Bit Completion Poller

This block decides whether an embedded program or erase operation inside a NOR flash has finished. It does not look at a ready pin. It issues pairs of back-to-back reads to one status address and compares the toggle bit (data bit 6) across the two reads. When that bit moves, it also looks at the limit-exceeded bit (data bit 5) of the first read of the pair.

A start pulse carries the status address and a timeout limit counted in clock cycles. The poller runs its reads over a simple request/valid read port, one read at a time. It finishes with one of three verdicts: success, error or timeout. The verdict and a done flag stay on the outputs until the next start pulse.

Top module: `nor_done_poller`

## Requirements
- R1: While the poller is idle or done, a start pulse latches `addr_i` and `limit_i` and raises `busy_o` on the next cycle. Every read of the run is then issued at the latched address.
- R2: Each read holds `rd_req_o` high until a cycle in which `rd_valid_i` is also high. Data is captured only in that cycle, and the next read of the pair starts only after it.
- R3: If bit 6 has the same value in both reads of a pair, the run ends with result code 2'b01 (success).
- R4: If bit 6 differs within a pair and bit 5 of the first read is 0, a fresh pair of reads follows.
- R5: If bit 6 differs within a pair and bit 5 of the first read is 1, a confirming pair follows. A stable bit 6 in that confirming pair gives success.
- R6: If bit 6 still differs in the confirming pair and bit 5 of its first read is 1, the run ends with code 2'b10 (error). If that bit 5 is 0, polling restarts with a fresh pair.
- R7: Each busy cycle advances an elapsed count that starts at 0. If no verdict has been reached when the count equals the limit, the run ends with code 2'b11 (timeout). `done_o` is then first seen limit+1 cycles after the start edge.
- R8: A success or error decision made in the same cycle that the limit is reached takes priority over timeout.
- R9: `done_o` and `result_o` hold their values until the next start. A start pulse while `busy_o` is high has no effect on the address, the limit or the run.
- R10: After reset, `busy_o`, `done_o` and `rd_req_o` are 0 and `result_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| addr_i | input | AW | Status address to poll |
| limit_i | input | TW | Timeout limit in clock cycles |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Verdict available |
| result_o | output | 2 | 00 none, 01 success, 10 error, 11 timeout |

## Verification
The assertions assume that the read port raises `rd_valid_i` only while a request is pending, and that start is a pulse sampled on clock edges. The bench's read responder keeps to this. It raises valid only after it sees `rd_req_o`, after a chosen latency, and drops it in the cycle after each capture. It then serves the next word of a per-scenario status sequence. Once that sequence is used up, it serves an endless toggling pattern with bit 5 clear. Timeout runs therefore never reach a decision.

// File: rtl/npoll_pkg.sv
package npoll_pkg;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_OK   = 2'b01,
    RES_ERR  = 2'b10,
    RES_TMO  = 2'b11
  } npoll_res_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_A1,
    PS_B1,
    PS_A2,
    PS_B2,
    PS_DONE
  } npoll_state_e;

  typedef enum logic [1:0] {
    ACT_OK,
    ACT_ERR,
    ACT_CONFIRM,
    ACT_RETRY
  } npoll_act_e;

  // Verdict on one completed pair of reads.
  function automatic npoll_act_e judge_pair(input logic tog_a, input logic tog_b,
                                            input logic lim_a, input logic confirming);
    if (tog_a == tog_b)  return ACT_OK;
    if (!lim_a)          return ACT_RETRY;
    if (confirming)      return ACT_ERR;
    return ACT_CONFIRM;
  endfunction

  // Saturating increment of the elapsed counter.
  function automatic logic [63:0] sat_inc(input logic [63:0] v, input logic [63:0] maxv);
    return (v >= maxv) ? maxv : v + 64'd1;
  endfunction

endpackage

// File: rtl/npoll_timer.sv
module npoll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] limit_i,
  input  logic          run,
  output logic          expired
);
  import npoll_pkg::*;

  localparam logic [63:0] CNT_MAX = (64'd1 << TW) - 64'd1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit_q;
  logic [63:0]   cnt_next;

  assign cnt_next = sat_inc(64'(cnt_q), CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= '0;
    end else if (go) begin
      cnt_q   <= '0;
      limit_q <= limit_i;
    end else if (run) begin
      cnt_q   <= cnt_next[TW-1:0];
    end
  end

  assign expired = run && (cnt_q >= limit_q);

endmodule

// File: rtl/npoll_reader.sv
module npoll_reader #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TOG_BIT = 6,
  parameter int LIM_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr_i,
  input  logic          read_en,
  input  logic          first_slot,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          fire,
  output logic          hold_tog,
  output logic          hold_lim,
  output logic          cur_tog
);

  logic [AW-1:0] addr_q;
  logic          unused_data_bits;

  assign unused_data_bits = ^rd_data_i;

  assign rd_req_o  = read_en;
  assign rd_addr_o = addr_q;
  assign fire      = read_en && rd_valid_i;
  assign cur_tog   = rd_data_i[TOG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hold_tog <= 1'b0;
      hold_lim <= 1'b0;
    end else begin
      if (go) addr_q <= addr_i;
      if (fire && first_slot) begin
        hold_tog <= rd_data_i[TOG_BIT];
        hold_lim <= rd_data_i[LIM_BIT];
      end
    end
  end

endmodule

// File: rtl/npoll_seq.sv
module npoll_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       fire,
  input  logic       hold_tog,
  input  logic       hold_lim,
  input  logic       cur_tog,
  input  logic       expired,
  output logic       read_en,
  output logic       first_slot,
  output logic       busy,
  output logic       done,
  output logic       decide_ok,
  output logic       decide_err,
  output logic [1:0] result
);
  import npoll_pkg::*;

  npoll_state_e st_q, st_d;
  npoll_res_e   res_q, res_d;
  npoll_act_e   act;
  logic         pair_end;
  logic         confirming;

  assign busy       = (st_q == PS_A1) || (st_q == PS_B1) || (st_q == PS_A2) || (st_q == PS_B2);
  assign done       = (st_q == PS_DONE);
  assign read_en    = busy;
  assign first_slot = (st_q == PS_A1) || (st_q == PS_A2);
  assign confirming = (st_q == PS_B2);
  assign pair_end   = fire && ((st_q == PS_B1) || (st_q == PS_B2));
  assign act        = judge_pair(hold_tog, cur_tog, hold_lim, confirming);
  assign decide_ok  = pair_end && (act == ACT_OK);
  assign decide_err = pair_end && (act == ACT_ERR);
  assign result     = res_q;

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    unique case (st_q)
      PS_IDLE, PS_DONE: begin
        if (go) begin
          st_d  = PS_A1;
          res_d = RES_NONE;
        end
      end
      PS_A1: if (fire) st_d = PS_B1;
      PS_A2: if (fire) st_d = PS_B2;
      PS_B1, PS_B2: begin
        if (pair_end) begin
          unique case (act)
            ACT_OK:      st_d = PS_DONE;
            ACT_ERR:     st_d = PS_DONE;
            ACT_CONFIRM: st_d = PS_A2;
            ACT_RETRY:   st_d = PS_A1;
          endcase
        end
      end
      default: st_d = PS_IDLE;
    endcase
    if (decide_ok) begin
      res_d = RES_OK;
    end else if (decide_err) begin
      res_d = RES_ERR;
    end else if (expired) begin
      st_d  = PS_DONE;
      res_d = RES_TMO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      res_q <= RES_NONE;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int TW      = 16,
  parameter int TOG_BIT = 6,
  parameter int LIM_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] limit_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);

  logic go;
  logic read_en;
  logic first_slot;
  logic fire;
  logic hold_tog;
  logic hold_lim;
  logic cur_tog;
  logic expired;
  logic decide_ok;
  logic decide_err;

  assign go = start_i && !busy_o;

  npoll_reader #(.AW(AW), .DW(DW), .TOG_BIT(TOG_BIT), .LIM_BIT(LIM_BIT)) u_reader (
    .clk(clk), .rst_n(rst_n), .go(go), .addr_i(addr_i),
    .read_en(read_en), .first_slot(first_slot),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .fire(fire),
    .hold_tog(hold_tog), .hold_lim(hold_lim), .cur_tog(cur_tog)
  );

  npoll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .limit_i(limit_i),
    .run(busy_o), .expired(expired)
  );

  npoll_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .fire(fire),
    .hold_tog(hold_tog), .hold_lim(hold_lim), .cur_tog(cur_tog),
    .expired(expired), .read_en(read_en), .first_slot(first_slot),
    .busy(busy_o), .done(done_o), .decide_ok(decide_ok),
    .decide_err(decide_err), .result(result_o)
  );

endmodule

// File: rtl/npoll_chk.sv
module npoll_chk #(
  parameter int AW = 24,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [TW-1:0] limit_i,
  input logic          rd_req_o,
  input logic          rd_valid_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    result_o
);

  logic [TW-1:0] cyc_q;
  logic [TW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      lim_q <= '0;
    end else if (start_i && !busy_o) begin
      cyc_q <= '0;
      lim_q <= limit_i;
    end else if (busy_o && (cyc_q != '1)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o || done_o);

  // R1
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(rd_addr_o));

  // R9
  verdict_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(result_o));

  // R9
  done_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != 2'b00) && !busy_o);

  // R7
  no_early_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) && (result_o == 2'b11) |-> cyc_q >= lim_q);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !busy_o && !done_o && !rd_req_o);

endmodule

bind nor_done_poller npoll_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .limit_i(limit_i),
  .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_addr_o(rd_addr_o),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/nor_done_poller_test.sv
module nor_done_poller_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-1:0] limit_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    result_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] seq_mem [0:15];
  int seq_len = 0;
  int lat = 0;
  int idx = 0;
  int wcnt = 0;
  int rcount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_done_poller #(.AW(AW), .DW(DW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .limit_i(limit_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [15:0] word_at(input int i);
    if (i < seq_len) return seq_mem[i];
    return (i % 2 == 1) ? 16'h0040 : 16'h0000;
  endfunction

  // Independent reference: walk the status words pair by pair.
  task automatic predict(output int code, output int reads);
    int i = 0;
    bit confirm = 0;
    code = 3;
    for (int n = 0; n < 100; n++) begin
      logic [15:0] a = word_at(i);
      logic [15:0] b = word_at(i + 1);
      i += 2;
      if (a[6] == b[6]) begin code = 1; break; end
      if (!a[5]) begin confirm = 0; continue; end
      if (confirm) begin code = 2; break; end
      confirm = 1;
    end
    reads = i;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Read responder: valid after lat cycles of pending request.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid_i) begin
        rd_valid_i = 1'b0;
        idx++;
        rcount++;
        wcnt = 0;
      end
      if (rd_req_o && !rd_valid_i) begin
        if (wcnt >= lat) begin
          rd_valid_i = 1'b1;
          rd_data_i  = word_at(idx);
        end else begin
          wcnt++;
        end
      end
    end
  end

  // Launch a run; inject an extra start pulse at cycle inj (negative: none).
  task automatic run_poll(input logic [AW-1:0] addr, input int limit, input int l,
                          input int inj, output int elapsed);
    @(negedge clk);
    @(negedge clk);
    idx = 0; wcnt = 0; rcount = 0; lat = l;
    start_i = 1'b1; addr_i = addr; limit_i = TW'(limit);
    @(negedge clk);
    start_i = 1'b0;
    elapsed = 0;
    chk(busy_o && !done_o && rd_addr_o == addr, "R1", int'(rd_addr_o), int'(addr));
    while (!done_o && elapsed < 5000) begin
      if (elapsed == inj) begin
        start_i = 1'b1; addr_i = addr ^ 24'h00FFFF; limit_i = 16'd3;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      elapsed++;
      if (busy_o) chk(rd_addr_o == addr, "R1", int'(rd_addr_o), int'(addr));
    end
    start_i = 1'b0;
  endtask

  task automatic decision_case(input string req, input int l);
    int ec, er, el;
    predict(ec, er);
    run_poll(24'h0A5550, 1000, l, -1, el);
    chk(int'(result_o) == ec, req, int'(result_o), ec);
    chk(rcount == er, {req, " R2 reads"}, rcount, er);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !rd_req_o, "R10", {busy_o, done_o, rd_req_o}, 0);
    chk(result_o == 2'b00, "R10", int'(result_o), 0);
  endtask

  task automatic t_stable();
    seq_mem[0] = 16'h0040; seq_mem[1] = 16'h0040; seq_len = 2;
    decision_case("R3", 0);
    seq_mem[0] = 16'h0000; seq_mem[1] = 16'h0000; seq_len = 2;
    decision_case("R3", 3);
  endtask

  task automatic t_retry();
    seq_mem[0] = 16'h0000; seq_mem[1] = 16'h0060;
    seq_mem[2] = 16'h0040; seq_mem[3] = 16'h0040; seq_len = 4;
    decision_case("R4", 1);
  endtask

  task automatic t_confirm_ok();
    seq_mem[0] = 16'h0020; seq_mem[1] = 16'h0060;
    seq_mem[2] = 16'h0060; seq_mem[3] = 16'h0060; seq_len = 4;
    decision_case("R5", 0);
  endtask

  task automatic t_error();
    seq_mem[0] = 16'h0020; seq_mem[1] = 16'h0060;
    seq_mem[2] = 16'h0020; seq_mem[3] = 16'h0060; seq_len = 4;
    decision_case("R6", 2);
  endtask

  task automatic t_confirm_restart();
    seq_mem[0] = 16'h0020; seq_mem[1] = 16'h0060;
    seq_mem[2] = 16'h0000; seq_mem[3] = 16'h0040;
    seq_mem[4] = 16'h0040; seq_mem[5] = 16'h0040; seq_len = 6;
    decision_case("R6", 0);
  endtask

  task automatic t_timeout();
    int el;
    seq_len = 0;
    run_poll(24'h000100, 20, 1, -1, el);
    chk(result_o == 2'b11, "R7", int'(result_o), 3);
    chk(el == 21, "R7 cycles", el, 21);
  endtask

  task automatic t_priority();
    int el;
    seq_mem[0] = 16'h0040; seq_mem[1] = 16'h0040; seq_len = 2;
    run_poll(24'h000200, 1, 0, -1, el);
    chk(result_o == 2'b01, "R8", int'(result_o), 1);
    chk(el == 2, "R8 cycles", el, 2);
    run_poll(24'h000200, 0, 0, -1, el);
    chk(result_o == 2'b11, "R7 zero limit", int'(result_o), 3);
    chk(el == 1, "R7 zero limit cycles", el, 1);
  endtask

  task automatic t_hold_ignore();
    int el;
    seq_len = 0;
    run_poll(24'h123456, 30, 2, 5, el);
    chk(result_o == 2'b11, "R9 ignored start", int'(result_o), 3);
    chk(el == 31, "R9 ignored start cycles", el, 31);
    repeat (6) @(negedge clk);
    chk(done_o && result_o == 2'b11, "R9 held", int'(result_o), 3);
    start_i = 1'b1; addr_i = 24'h000300; limit_i = 16'd50;
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && busy_o, "R9 cleared by start", done_o, 0);
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_stable();
    t_retry();
    t_confirm_ok();
    t_error();
    t_confirm_restart();
    t_timeout();
    t_priority();
    t_hold_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule